// File: doc/BRIEF.md
# Push-Button Register File Editor

This block keeps a small bank of byte-wide registers that an operator browses and edits with four push buttons. A selection pointer names one register at a time. Two buttons walk the pointer forwards and backwards through the bank, and the pointer wraps at both ends. The other two buttons add one to or subtract one from the byte held in the selected register. The change is a read-modify-write of that entry in a single cycle, so the stored contents change in place.

The raw button lines are asynchronous. Each one passes through a two-stage synchronizer and a rising-edge detector, so one press gives one step however long the button is held. An action happens only when exactly one button is down and that button has just been pressed. The outputs are the current pointer and the byte it selects, meant to feed a display. The byte output always follows the selected entry, including in the cycle right after that entry was edited.

Top module: `regfile_button_editor`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets the pointer to 0 and clears every register to 0.
- R2: A press of btn_raw[3] alone advances the pointer by one, and pointer 15 wraps to 0.
- R3: A press of btn_raw[2] alone moves the pointer back by one, and pointer 0 wraps to 15.
- R4: A press of btn_raw[1] alone increments the selected register by one modulo 256, so 255 becomes 0.
- R5: A press of btn_raw[0] alone decrements the selected register by one modulo 256, so 0 becomes 255.
- R6: An action is taken only when exactly one synchronized button is high and that button rose in the same cycle. Any press pattern with two or more buttons, including a new press while another button is still held, changes neither the pointer nor any register.
- R7: A button held high for any number of cycles produces exactly one step.
- R8: A raw button change is first visible at the outputs after the third rising clock edge that samples it: two synchronizer stages, then the update edge.
- R9: An increment or decrement writes only the selected entry. All other entries keep their values.
- R10: sel_value always equals the contents of the entry at sel_index, including the cycle after that entry is modified or the pointer moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 4 | Raw buttons: [3] pointer up, [2] pointer down, [1] value up, [0] value down |
| sel_index | output | IDX_W (4) | Current register pointer |
| sel_value | output | DATA_W (8) | Contents of the selected register |

## Verification
Moving the pointer and editing the selected value are the two functions that could be asked for in the same cycle. That happens either when a pointer button and a value button rise together, or when a value button is pressed while a pointer button is still held. The bench drives every multi-button pattern together and also the staggered held-then-pressed case. It judges them by confirming that the pointer and the displayed byte are unchanged, and that a walk over the bank later finds every entry as the model predicts. The checker adds a property that at most one step strobe fires per cycle, so a pointer move and a write can never coincide.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int NUM_BTN = 4;
  // Bit positions of the button functions; the decoder relies on them.
  localparam int BTN_VAL_DN = 0;
  localparam int BTN_VAL_UP = 1;
  localparam int BTN_IDX_DN = 2;
  localparam int BTN_IDX_UP = 3;
endpackage

// File: rtl/rfe_btn_conditioner.sv
module rfe_btn_conditioner #(
  parameter int NUM_BTN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] raw_i,
  output logic [NUM_BTN-1:0] level_o,
  output logic [NUM_BTN-1:0] rise_o
);
  logic [NUM_BTN-1:0] meta_q;
  logic [NUM_BTN-1:0] sync_q;
  logic [NUM_BTN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BTN; b++) begin : g_edge
      assign rise_o[b] = sync_q[b] & ~prev_q[b];
    end
  endgenerate

  assign level_o = sync_q;
endmodule

// File: rtl/rfe_action_decoder.sv
module rfe_action_decoder
  import rfe_pkg::*;
(
  input  logic [NUM_BTN-1:0] level_i,
  input  logic [NUM_BTN-1:0] rise_i,
  output logic               idx_up_o,
  output logic               idx_dn_o,
  output logic               val_up_o,
  output logic               val_dn_o
);
  logic single_held;
  logic [NUM_BTN-1:0] fire;

  assign single_held = $onehot(level_i);
  assign fire        = rise_i & {NUM_BTN{single_held}};

  assign idx_up_o = fire[BTN_IDX_UP];
  assign idx_dn_o = fire[BTN_IDX_DN];
  assign val_up_o = fire[BTN_VAL_UP];
  assign val_dn_o = fire[BTN_VAL_DN];
endmodule

// File: rtl/rfe_index_ptr.sv
module rfe_index_ptr #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] cur,
                                                input logic up);
    if (up) return (cur == LAST) ? '0 : cur + IDX_W'(1);
    else    return (cur == '0) ? LAST : cur - IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (up_i) idx_q <= step_idx(idx_q, 1'b1);
    else if (dn_i) idx_q <= step_idx(idx_q, 1'b0);
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/rfe_reg_store.sv
module rfe_reg_store #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] rd_data_o
);
  function automatic logic [DATA_W-1:0] step_val(input logic [DATA_W-1:0] cur,
                                                 input logic up);
    return up ? cur + DATA_W'(1) : cur - DATA_W'(1);
  endfunction

  logic [DATA_W-1:0] entry_q [NUM_REGS];
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] nxt_val;

  assign cur_val = entry_q[addr_i];
  assign wr_en_o = inc_i | dec_i;
  assign nxt_val = step_val(cur_val, inc_i);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)
        entry_q[i] <= '0;
      else if (wr_en_o && (addr_i == IDX_W'(i)))
        entry_q[i] <= nxt_val;
    end
  end

  assign rd_data_o = cur_val;
endmodule

// File: rtl/regfile_button_editor.sv
module regfile_button_editor
  import rfe_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        btn_raw,
  output logic [IDX_W-1:0]  sel_index,
  output logic [DATA_W-1:0] sel_value
);
  // Named internal events, observed by the bound checker.
  logic [NUM_BTN-1:0] btn_lvl;
  logic [NUM_BTN-1:0] btn_rise;
  logic idx_up, idx_dn, val_up, val_dn;
  logic wr_en;

  rfe_btn_conditioner #(.NUM_BTN(NUM_BTN)) cond_i (
    .clk(clk), .rst(rst), .raw_i(btn_raw),
    .level_o(btn_lvl), .rise_o(btn_rise)
  );

  rfe_action_decoder dec_i (
    .level_i(btn_lvl), .rise_i(btn_rise),
    .idx_up_o(idx_up), .idx_dn_o(idx_dn),
    .val_up_o(val_up), .val_dn_o(val_dn)
  );

  rfe_index_ptr #(.NUM_REGS(NUM_REGS)) ptr_i (
    .clk(clk), .rst(rst), .up_i(idx_up), .dn_i(idx_dn), .idx_o(sel_index)
  );

  rfe_reg_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst(rst), .addr_i(sel_index),
    .inc_i(val_up), .dec_i(val_dn),
    .wr_en_o(wr_en), .rd_data_o(sel_value)
  );
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        btn_lvl,
  input logic [3:0]        btn_rise,
  input logic              idx_up,
  input logic              idx_dn,
  input logic              val_up,
  input logic              val_dn,
  input logic              wr_en,
  input logic [IDX_W-1:0]  sel_index,
  input logic [DATA_W-1:0] sel_value
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);
  logic any_act;
  assign any_act = idx_up | idx_dn | val_up | val_dn;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (sel_index == '0) && (sel_value == '0));

  assert_idx_up_R2: assert property (@(posedge clk) disable iff (rst)
    idx_up |=> sel_index == (($past(sel_index) == LAST) ? '0 : $past(sel_index) + IDX_W'(1)));

  assert_idx_dn_R3: assert property (@(posedge clk) disable iff (rst)
    idx_dn |=> sel_index == (($past(sel_index) == '0) ? LAST : $past(sel_index) - IDX_W'(1)));

  assert_val_up_R4: assert property (@(posedge clk) disable iff (rst)
    val_up |=> (sel_value == $past(sel_value) + DATA_W'(1)) && $stable(sel_index));

  assert_val_dn_R5: assert property (@(posedge clk) disable iff (rst)
    val_dn |=> (sel_value == $past(sel_value) - DATA_W'(1)) && $stable(sel_index));

  assert_multi_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(btn_lvl) > 1) |-> !any_act);

  assert_one_action_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({idx_up, idx_dn, val_up, val_dn}));

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !any_act |=> $stable(sel_index) && $stable(sel_value));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    (|btn_rise) |=> !(|(btn_rise & $past(btn_rise))));

  assert_write_idx_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !(idx_up || idx_dn));
endmodule

bind regfile_button_editor rfe_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .btn_lvl(btn_lvl), .btn_rise(btn_rise),
  .idx_up(idx_up), .idx_dn(idx_dn), .val_up(val_up), .val_dn(val_dn),
  .wr_en(wr_en), .sel_index(sel_index), .sel_value(sel_value)
);

// File: tb/regfile_button_editor_tb_top.sv
module regfile_button_editor_tb_top;
  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] btn = 4'b0;
  logic [3:0] sel_index;
  logic [7:0] sel_value;

  int checks = 0;
  int failures = 0;
  int exp_idx = 0;
  int exp_mem [NREG];

  always #4 clk = ~clk;

  regfile_button_editor dut_i (
    .clk(clk), .rst(rst), .btn_raw(btn),
    .sel_index(sel_index), .sel_value(sel_value)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_both(input string req);
    chk(req, int'(sel_index), exp_idx);
    chk(req, int'(sel_value), exp_mem[exp_idx]);
  endtask

  task automatic press(input logic [3:0] pat, input int hold);
    @(negedge clk) btn = pat;
    repeat (hold) @(negedge clk);
    btn = 4'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic idx_up();   press(4'b1000, 3); exp_idx = (exp_idx + 1) % NREG; endtask
  task automatic idx_dn();   press(4'b0100, 3); exp_idx = (exp_idx + NREG - 1) % NREG; endtask
  task automatic val_up();   press(4'b0010, 3); exp_mem[exp_idx] = (exp_mem[exp_idx] + 1) % 256; endtask
  task automatic val_dn();   press(4'b0001, 3); exp_mem[exp_idx] = (exp_mem[exp_idx] + 255) % 256; endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_idx = 0;
    for (int i = 0; i < NREG; i++) exp_mem[i] = 0;
    @(negedge clk);
  endtask

  task automatic walk_verify(input string req);
    for (int i = 0; i < NREG; i++) begin
      idx_up();
      chk_both(req);
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk_both("R1 reset state");

    // R2 walk up across wrap; R1 all entries zero
    walk_verify("R2 R1 walk up, zero contents");
    chk("R2 wrap to 0", int'(sel_index), 0);

    // R3 wrap down
    idx_dn(); chk_both("R3 0 wraps to 15");
    idx_dn(); chk_both("R3 step down");
    idx_up(); idx_up();
    chk("R3 back at 0", int'(sel_index), 0);

    // R4 R9 fill each entry with i+1
    for (int i = 0; i < NREG; i++) begin
      for (int k = 0; k <= i; k++) val_up();
      chk_both("R4 R10 fill value");
      idx_up();
    end
    walk_verify("R9 R10 entries kept");

    // R5 decrement wrap on entry 0 (value 1)
    val_dn(); chk_both("R5 decrement");
    val_dn(); chk_both("R5 0 wraps to 255");
    val_up(); chk_both("R4 255 wraps to 0");

    // R4 long climb on entry 1 (value 2) to 255 then 0
    idx_up();
    for (int k = 0; k < 253; k++) val_up();
    chk("R4 reach 255", int'(sel_value), 255);
    val_up(); chk_both("R4 wrap after climb");
    walk_verify("R9 bank after climb");

    // R6 every multi-button pattern is ignored
    for (int p = 0; p < 16; p++) begin
      if ($countones(p) > 1) begin
        press(4'(p), 3);
        chk_both("R6 multi-button ignored");
      end
    end

    // R6 held pointer button then value button pressed
    @(negedge clk) btn = 4'b1000;
    repeat (6) @(negedge clk);
    exp_idx = (exp_idx + 1) % NREG;
    chk_both("R6 held button steps once");
    btn = 4'b1010;
    repeat (6) @(negedge clk);
    chk_both("R6 staggered second press ignored");
    btn = 4'b0;
    repeat (5) @(negedge clk);
    chk_both("R6 release no action");
    walk_verify("R6 R9 bank untouched");

    // R7 long hold
    press(4'b0010, 40);
    exp_mem[exp_idx] = (exp_mem[exp_idx] + 1) % 256;
    chk_both("R7 long hold one increment");
    press(4'b1000, 40);
    exp_idx = (exp_idx + 1) % NREG;
    chk_both("R7 long hold one pointer step");

    // R8 latency: drive at negedge, outputs change after third edge
    @(negedge clk) btn = 4'b0010;
    @(negedge clk);
    @(negedge clk);
    chk("R8 unchanged after two edges", int'(sel_value), exp_mem[exp_idx]);
    @(negedge clk);
    exp_mem[exp_idx] = (exp_mem[exp_idx] + 1) % 256;
    chk("R8 R10 changed after third edge", int'(sel_value), exp_mem[exp_idx]);
    btn = 4'b0;
    repeat (5) @(negedge clk);
    walk_verify("R9 R10 final bank");

    // R1 reset mid-run
    do_reset();
    chk_both("R1 reset mid-run");
    walk_verify("R1 all cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule